// File: doc/BRIEF.md
# Dual-Network Time-Shared FIR Filter

The block holds two FIR networks. Each has a bank of eight signed 16x16 multipliers that is reused over several clock cycles, so a lower sample rate buys a longer filter. Samples are signed 16-bit values, results are 32-bit accumulations that wrap, and each network keeps its own 64-entry coefficient store, which is loaded through a small write port.

A five-bit control word picks the wiring and the rate/length code. In independent wiring, bus `da` feeds network A, whose result leaves on `f_data`, and bus `db` feeds network B, whose result leaves on `x_data`. In cascaded wiring, `da` feeds network A, and network B filters bits [23:8] of each A result, so its final output appears on `x_data`. A strobe marks each accepted input, and a strobe on each result bus marks every result, which arrives at a fixed, code-dependent number of cycles after its input. The F bus carries a registered drive-enable for the pad driver outside the block.

Top module: `dual_fir`

## Requirements
- R1: The control word `ctrl` is laid out as follows. Bit [0] selects cascaded wiring (1) or independent wiring (0). Bits [3:1] hold the rate/length code. Bit [4] must be 0; when it is 1, the configuration is invalid.
- R2: Code c selects T = 8·2^((c+1)/2) taps, which is 8, 16, 16, 32, 32, 64 or 64 for codes 0 through 6. Input samples are accepted one per 2^(c>>1) cycles. Code bit 0 requests decimation by two.
- R3: Each result equals the sum over i < T of coef[i]·x[n−i], taken modulo 2^32. Here x[n] is the newest accepted sample, and the sample history reads as zero after reset.
- R4: With decimation, a result is produced only for the 2nd, 4th, 6th and later even-numbered accepted samples after reset.
- R5: In independent wiring, a result appears L cycles after its input sample is taken, with L = 16, 17, 16, 18, 20, 24 or 24 for codes 0 through 6.
- R6: In independent wiring, network A (input `da`) drives `f_data`/`f_valid` and network B (input `db`) drives `x_data`/`x_valid`. Both networks share one configuration and run in lockstep.
- R7: In cascaded wiring, only `da` is used. Network B's input is bits [23:8] of each network A result, read as a signed value. The final result appears on `x_data`, and `f_valid` stays low.
- R8: In cascaded wiring, the latency from a `da` sample to its `x_data` result is 27, 28, 36 or 40 cycles for codes 0, 2, 4 and 6.
- R9: Code 7, a decimating code with cascaded wiring, or bit [4] set produces no valid result on either bus.
- R10: `f_drive` equals the inverse of `f_oe_n` as sampled at the previous rising clock edge.
- R11: A write with `cw_en` high stores `cw_data` as tap `cw_addr` (0 to 63). It goes to network A when `cw_net` is 0 and to network B when `cw_net` is 1.
- R12: During reset, and directly after it, `f_valid`, `x_valid` and `f_drive` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 5 | Configuration word (wiring, rate/length code, reserved bit) |
| cw_en | input | 1 | Coefficient write strobe |
| cw_net | input | 1 | Coefficient target network (0 = A, 1 = B) |
| cw_addr | input | 6 | Coefficient tap index |
| cw_data | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Marks an accepted input sample slot |
| da | input | 16 | Signed sample for network A |
| db | input | 16 | Signed sample for network B (independent wiring) |
| f_oe_n | input | 1 | Active-low drive request for the F bus |
| f_data | output | 32 | Network A result |
| f_drive | output | 1 | Registered F bus pad drive enable |
| f_valid | output | 1 | Marks a valid `f_data` result |
| x_data | output | 32 | Network B result (final result when cascaded) |
| x_valid | output | 1 | Marks a valid `x_data` result |

## Verification
The assertions assume that `ctrl` changes only while reset is held, so no result computed under one configuration is still in flight under another. They also assume that `in_valid` pulses exactly once per input period of the chosen code. The stimulus reapplies reset with the new word already set for every configuration, and drives samples strictly on the code's period. It sweeps every valid code in both wirings plus the invalid words, and compares each cycle against a convolution model computed in the bench.

// File: rtl/dfir_pkg.sv
// Shared constants and configuration helpers for the dual-network FIR.
// Assumes the fixed rate/length code set of codes 0..6; code 7 is reserved.
package dfir_pkg;

    localparam int SAMP_W  = 16;
    localparam int RES_W   = 32;
    localparam int N_LANES = 8;
    localparam int N_TAPS  = 64;
    localparam int MAX_DLY = 32;

    typedef enum logic [1:0] {
        NET_OFF = 2'd0,
        NET_IND = 2'd1,
        NET_CAS = 2'd2
    } net_mode_e;

    // Multiplier passes per result for a rate/length code.
    function automatic int pass_cnt(input logic [2:0] code);
        return 1 << ((int'(code) + 1) / 2);
    endfunction

    // Input-to-result latency with independent wiring.
    function automatic int lat_ind(input logic [2:0] code);
        case (code)
            3'd0:    return 16;
            3'd1:    return 17;
            3'd2:    return 16;
            3'd3:    return 18;
            3'd4:    return 20;
            default: return 24;
        endcase
    endfunction

    // Input-to-result latency with cascaded wiring.
    function automatic int lat_cas(input logic [2:0] code);
        case (code)
            3'd0:    return 27;
            3'd2:    return 28;
            3'd4:    return 36;
            default: return 40;
        endcase
    endfunction

endpackage

// File: rtl/dfir_coef_bank.sv
// Coefficient store of one network: written one tap at a time, read one
// lane-group (N_LANES consecutive taps) per cycle for the multiplier bank.
// Assumes the write address is always below N_TAPS.
module dfir_coef_bank #(
    parameter int SW      = 16,
    parameter int LANES   = 8,
    parameter int NTAPS   = 64,
    localparam int TW     = $clog2(NTAPS),
    localparam int GW     = $clog2(NTAPS / LANES),
    localparam int MB     = $clog2(LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [TW-1:0]               waddr,
    input  logic [SW-1:0]               wdata,
    input  logic [GW-1:0]               rgroup,
    output logic [LANES-1:0][SW-1:0]    rcoef
);

    logic [NTAPS-1:0][SW-1:0] mem_q;

    // Store one coefficient per write strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar m = 0; m < LANES; m++) begin : g_rd
        assign rcoef[m] = mem_q[{rgroup, MB'(m)}];
    end

endmodule

// File: rtl/dfir_mac.sv
// One FIR network: sample history, per-result snapshot and a time-shared
// bank of LANES multipliers that covers (pass_last+1)*LANES taps.
// A result register pulses res_v exactly pass_last+1 cycles after the
// starting sample edge. Assumes in_v pulses no more often than the
// configured input period and that configuration is stable while en is high.
module dfir_mac #(
    parameter int SW      = 16,
    parameter int RW      = 32,
    parameter int LANES   = 8,
    parameter int NTAPS   = 64,
    localparam int GW     = $clog2(NTAPS / LANES),
    localparam int MB     = $clog2(LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        decim,
    input  logic [GW-1:0]               pass_last,
    input  logic                        in_v,
    input  logic [SW-1:0]               in_d,
    input  logic [LANES-1:0][SW-1:0]    coef,
    output logic [GW-1:0]               group,
    output logic                        res_v,
    output logic [RW-1:0]               res_d
);

    logic [NTAPS-1:0][SW-1:0] hist_q;
    logic [NTAPS-1:0][SW-1:0] snap_q;
    logic [GW-1:0]            grp_q;
    logic                     busy_q;
    logic                     phase_q;
    logic [RW-1:0]            acc_q;
    logic [RW-1:0]            partial;
    logic                     res_v_q;
    logic [RW-1:0]            res_d_q;
    logic                     take;
    logic                     start;

    assign take  = en && in_v;
    assign start = take && (!decim || phase_q);
    assign group = grp_q;
    assign res_v = res_v_q;
    assign res_d = res_d_q;

    // Sum of the current lane group's products, wrapping at RW bits.
    always_comb begin
        logic signed [2*SW-1:0] prod;
        partial = '0;
        for (int m = 0; m < LANES; m++) begin
            prod    = $signed(snap_q[{grp_q, MB'(m)}]) * $signed(coef[m]);
            partial = partial + RW'(prod);
        end
    end

    // History shift, decimation phase, pass sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            snap_q  <= '0;
            grp_q   <= '0;
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            acc_q   <= '0;
            res_v_q <= 1'b0;
            res_d_q <= '0;
        end else begin
            res_v_q <= 1'b0;
            if (take) begin
                hist_q <= {hist_q[NTAPS-2:0], in_d};
            end
            if (take && decim) begin
                phase_q <= ~phase_q;
            end
            if (busy_q) begin
                acc_q <= acc_q + partial;
                grp_q <= grp_q + 1'b1;
                if (grp_q == pass_last) begin
                    res_d_q <= acc_q + partial;
                    res_v_q <= 1'b1;
                    busy_q  <= 1'b0;
                end
            end
            if (start) begin
                snap_q <= {hist_q[NTAPS-2:0], in_d};
                grp_q  <= '0;
                acc_q  <= '0;
                busy_q <= 1'b1;
            end
            if (!en) begin
                busy_q  <= 1'b0;
                phase_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dfir_align.sv
// Programmable delay line that pads a network's compute latency up to the
// latency promised at the block edge. Output is tap sel (0-based), so the
// total extra delay is sel+1 cycles. Assumes sel is stable while data flows.
module dfir_align #(
    parameter int W       = 32,
    parameter int MAXD    = 32,
    localparam int SLW    = $clog2(MAXD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SLW-1:0]  sel,
    input  logic            in_v,
    input  logic [W-1:0]    in_d,
    output logic            out_v,
    output logic [W-1:0]    out_d
);

    logic [MAXD-1:0]        sv_q;
    logic [MAXD-1:0][W-1:0] sd_q;

    // Shift valid and data one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
            sd_q <= '0;
        end else begin
            sv_q <= {sv_q[MAXD-2:0], in_v};
            sd_q <= {sd_q[MAXD-2:0], in_d};
        end
    end

    assign out_v = sv_q[sel];
    assign out_d = sd_q[sel];

endmodule

// File: rtl/dual_fir.sv
// Dual-network FIR top: decodes the control word, routes buses for the
// independent or cascaded wiring, and aligns both result paths to the
// tabulated latency. Assumes ctrl changes only while rst_n is low and that
// in_valid pulses once per input period of the selected code.
module dual_fir
    import dfir_pkg::*;
#(
    parameter int SW      = SAMP_W,
    parameter int RW      = RES_W,
    parameter int LANES   = N_LANES,
    parameter int NTAPS   = N_TAPS,
    parameter int MAXD    = MAX_DLY,
    localparam int TW     = $clog2(NTAPS),
    localparam int GW     = $clog2(NTAPS / LANES),
    localparam int SLW    = $clog2(MAXD),
    localparam int MID_LO = RW / 2 - SW / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      ctrl,
    input  logic            cw_en,
    input  logic            cw_net,
    input  logic [TW-1:0]   cw_addr,
    input  logic [SW-1:0]   cw_data,
    input  logic            in_valid,
    input  logic [SW-1:0]   da,
    input  logic [SW-1:0]   db,
    input  logic            f_oe_n,
    output logic [RW-1:0]   f_data,
    output logic            f_drive,
    output logic            f_valid,
    output logic [RW-1:0]   x_data,
    output logic            x_valid
);

    logic [2:0]     code;
    logic           casc;
    logic           cfg_ok;
    net_mode_e      mode;
    logic [GW-1:0]  pass_last;
    logic [SLW-1:0] sel_a;
    logic [SLW-1:0] sel_b;
    logic           oe_q;

    logic [LANES-1:0][SW-1:0] coef_a, coef_b;
    logic [GW-1:0]  grp_a, grp_b;
    logic           ra_v, rb_v;
    logic [RW-1:0]  ra_d, rb_d;
    logic           b_in_v;
    logic [SW-1:0]  b_in_d;
    logic           b_decim;
    logic           aa_v, ab_v;
    logic [RW-1:0]  aa_d, ab_d;

    // Decode wiring, validity and per-path alignment taps from the control word.
    always_comb begin
        int p;
        code   = ctrl[3:1];
        casc   = ctrl[0];
        cfg_ok = !ctrl[4] && (code != 3'd7) && !(casc && code[0]);
        if (!cfg_ok)   mode = NET_OFF;
        else if (casc) mode = NET_CAS;
        else           mode = NET_IND;
        p         = pass_cnt(code);
        pass_last = GW'(p - 1);
        sel_a     = SLW'(lat_ind(code) - p - 1);
        if (casc) sel_b = SLW'(lat_cas(code) - 2 * p - 2);
        else      sel_b = SLW'(lat_ind(code) - p - 1);
    end

    // Register the F bus drive request.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !f_oe_n;
    end

    dfir_coef_bank #(.SW(SW), .LANES(LANES), .NTAPS(NTAPS)) u_coef_a (
        .clk(clk), .rst_n(rst_n), .we(cw_en && !cw_net), .waddr(cw_addr),
        .wdata(cw_data), .rgroup(grp_a), .rcoef(coef_a));

    dfir_coef_bank #(.SW(SW), .LANES(LANES), .NTAPS(NTAPS)) u_coef_b (
        .clk(clk), .rst_n(rst_n), .we(cw_en && cw_net), .waddr(cw_addr),
        .wdata(cw_data), .rgroup(grp_b), .rcoef(coef_b));

    dfir_mac #(.SW(SW), .RW(RW), .LANES(LANES), .NTAPS(NTAPS)) u_mac_a (
        .clk(clk), .rst_n(rst_n), .en(mode != NET_OFF), .decim(code[0]),
        .pass_last(pass_last), .in_v(in_valid), .in_d(da), .coef(coef_a),
        .group(grp_a), .res_v(ra_v), .res_d(ra_d));

    assign b_in_v  = (mode == NET_CAS) ? ra_v : in_valid;
    assign b_in_d  = (mode == NET_CAS) ? ra_d[MID_LO +: SW] : db;
    assign b_decim = (mode == NET_CAS) ? 1'b0 : code[0];

    dfir_mac #(.SW(SW), .RW(RW), .LANES(LANES), .NTAPS(NTAPS)) u_mac_b (
        .clk(clk), .rst_n(rst_n), .en(mode != NET_OFF), .decim(b_decim),
        .pass_last(pass_last), .in_v(b_in_v), .in_d(b_in_d), .coef(coef_b),
        .group(grp_b), .res_v(rb_v), .res_d(rb_d));

    dfir_align #(.W(RW), .MAXD(MAXD)) u_align_a (
        .clk(clk), .rst_n(rst_n), .sel(sel_a), .in_v(ra_v), .in_d(ra_d),
        .out_v(aa_v), .out_d(aa_d));

    dfir_align #(.W(RW), .MAXD(MAXD)) u_align_b (
        .clk(clk), .rst_n(rst_n), .sel(sel_b), .in_v(rb_v), .in_d(rb_d),
        .out_v(ab_v), .out_d(ab_d));

    assign f_data  = aa_d;
    assign f_drive = oe_q;
    assign f_valid = aa_v && (mode == NET_IND);
    assign x_data  = ab_d;
    assign x_valid = ab_v && (mode != NET_OFF);

endmodule

// File: rtl/dual_fir_chk.sv
// Property checker for dual_fir, attached by bind. Assumes ctrl changes only
// while rst_n is low.
module dual_fir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctrl,
    input logic       f_oe_n,
    input logic       f_drive,
    input logic       f_valid,
    input logic       x_valid
);

    // R10: drive enable follows the request one edge later.
    a_r10_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |=> f_drive);
    a_r10_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        f_oe_n |=> !f_drive);

    // R7: cascaded wiring never flags the F bus.
    a_r7_f_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |-> !f_valid);

    // R9: invalid words produce no results.
    a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4] || ctrl[3:1] == 3'b111 || (ctrl[0] && ctrl[1]))
            |-> (!f_valid && !x_valid));

    // R4: decimated results never come on consecutive cycles.
    a_r4_decim_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (f_valid && ctrl[1]) |=> !f_valid);

    // R6: independent networks run in lockstep.
    a_r6_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> (f_valid == x_valid));

endmodule

bind dual_fir dual_fir_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .f_oe_n(f_oe_n),
    .f_drive(f_drive), .f_valid(f_valid), .x_valid(x_valid));

// File: tb/sim_dual_fir.sv
`timescale 1ns/1ps
module sim_dual_fir;

    localparam int NS = 24;
    localparam int HZ = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctrl = '0;
    logic        cw_en = 1'b0;
    logic        cw_net = 1'b0;
    logic [5:0]  cw_addr = '0;
    logic [15:0] cw_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] da = '0;
    logic [15:0] db = '0;
    logic        f_oe_n = 1'b1;
    logic [31:0] f_data, x_data;
    logic        f_drive, f_valid, x_valid;

    dual_fir u0 (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cw_en(cw_en), .cw_net(cw_net),
        .cw_addr(cw_addr), .cw_data(cw_data), .in_valid(in_valid), .da(da),
        .db(db), .f_oe_n(f_oe_n), .f_data(f_data), .f_drive(f_drive),
        .f_valid(f_valid), .x_data(x_data), .x_valid(x_valid));

    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int pc = 0;
    bit done = 1'b0;

    bit fv[HZ];
    bit xv[HZ];
    int fd[HZ];
    int xd[HZ];
    int xa[NS];
    int xb[NS];
    int bs[NS];
    int ca[64];
    int cb[64];

    task automatic tick();
        @(posedge clk);
        pc++;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic int conv(input int s[NS], input int c[64], input int n,
                                input int taps);
        int acc = 0;
        for (int i = 0; i < taps; i++)
            if (n - i >= 0) acc = acc + c[i] * s[n - i];
        return acc;
    endfunction

    function automatic int tb_lat(input bit casc, input int code);
        if (casc) begin
            case (code)
                0: return 27;
                2: return 28;
                4: return 36;
                default: return 40;
            endcase
        end
        case (code)
            0: return 16;
            1: return 17;
            2: return 16;
            3: return 18;
            4: return 20;
            default: return 24;
        endcase
    endfunction

    // One configuration: reset, load coefficients (R11), stream, compare each cycle.
    task automatic run(input bit casc, input int code, input bit rsv, input string tag);
        int per, taps, lat, nexp, ngot;
        bit ok_cfg, decim;
        logic [31:0] a;
        shortint mid;
        rst_n = 1'b0;
        ctrl = {rsv, 3'(code), casc};
        in_valid = 1'b0;
        f_oe_n = 1'b1;
        tick();
        tick();
        chk(!f_valid && !x_valid && !f_drive, "R12", "valids in reset",
            {f_valid, x_valid, f_drive}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) begin
            ca[i] = int'(shortint'($urandom()));
            cb[i] = int'(shortint'($urandom()));
        end
        cw_en = 1'b1;
        for (int net = 0; net < 2; net++) begin
            for (int i = 0; i < 64; i++) begin
                cw_net = net[0];
                cw_addr = 6'(i);
                cw_data = 16'(net == 0 ? ca[i] : cb[i]);
                tick();
            end
        end
        cw_en = 1'b0;
        chk(!f_valid && !x_valid, "R12", "valids after load", {f_valid, x_valid}, 0);
        for (int i = 0; i < HZ; i++) begin
            fv[i] = 1'b0; xv[i] = 1'b0; fd[i] = 0; xd[i] = 0;
        end
        for (int n = 0; n < NS; n++) begin
            xa[n] = int'(shortint'($urandom()));
            xb[n] = int'(shortint'($urandom()));
        end
        // R2 table: taps, input period, decimation
        taps = 8 << ((code + 1) / 2);
        per = 1 << (code >> 1);
        decim = code[0];
        lat = tb_lat(casc, code);
        ok_cfg = !rsv && code != 7 && !(casc && decim);
        nexp = 0;
        for (int n = 0; n < NS; n++) begin
            int k = n * per + 1;
            if (!ok_cfg) continue;
            if (casc) begin
                a = conv(xa, ca, n, taps);
                mid = shortint'(a[23:8]);
                bs[n] = int'(mid);
                xv[k + lat] = 1'b1;
                xd[k + lat] = conv(bs, cb, n, taps);
                nexp++;
            end else if (!decim || (n % 2 == 1)) begin
                fv[k + lat] = 1'b1;
                fd[k + lat] = conv(xa, ca, n, taps);
                xv[k + lat] = 1'b1;
                xd[k + lat] = conv(xb, cb, n, taps);
                nexp++;
            end
        end
        pc = 0;
        ngot = 0;
        for (int t = 0; t < NS * per + 60; t++) begin
            in_valid = (t < NS * per) && (t % per == 0);
            da = 16'(xa[(t / per) % NS]);
            db = casc ? 16'h7fff : 16'(xb[(t / per) % NS]);
            tick();
            if (fv[pc] || f_valid)
                chk(fv[pc] && f_valid && f_data == fd[pc], tag,
                    $sformatf("F cyc %0d valid %0d/%0d", pc, f_valid, fv[pc]),
                    f_data, fd[pc]);
            if (xv[pc] || x_valid) begin
                chk(xv[pc] && x_valid && x_data == xd[pc], tag,
                    $sformatf("X cyc %0d valid %0d/%0d", pc, x_valid, xv[pc]),
                    x_data, xd[pc]);
                if (x_valid) ngot++;
            end
        end
        in_valid = 1'b0;
        chk(ngot == nexp, tag, "result count", ngot, nexp);
    endtask

    initial begin
        // Independent wiring, all codes (R2 R3 R5 R6; decimating codes R4)
        run(1'b0, 0, 1'b0, "R3 R5 R6 R11");
        run(1'b0, 1, 1'b0, "R4 R5 R6");
        run(1'b0, 2, 1'b0, "R2 R3 R5");
        run(1'b0, 3, 1'b0, "R4 R5");
        run(1'b0, 4, 1'b0, "R2 R5");
        run(1'b0, 5, 1'b0, "R4 R5");
        run(1'b0, 6, 1'b0, "R2 R3 R5");
        // Cascaded wiring (R7 R8)
        run(1'b1, 0, 1'b0, "R7 R8");
        run(1'b1, 2, 1'b0, "R7 R8");
        run(1'b1, 4, 1'b0, "R7 R8");
        run(1'b1, 6, 1'b0, "R3 R7 R8");
        // Invalid words (R1 R9)
        run(1'b0, 7, 1'b0, "R9");
        run(1'b1, 1, 1'b0, "R9");
        run(1'b0, 0, 1'b1, "R1 R9");
        // Registered drive enable (R10)
        f_oe_n = 1'b0;
        #1;
        chk(!f_drive, "R10", "drive before edge", f_drive, 0);
        tick();
        chk(f_drive, "R10", "drive after edge", f_drive, 1);
        f_oe_n = 1'b1;
        #1;
        chk(f_drive, "R10", "release before edge", f_drive, 1);
        tick();
        chk(!f_drive, "R10", "release after edge", f_drive, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule